// File: doc/BRIEF.md
# Passive LCD Frame Timing Controller

This block paces a passive STN panel from a linear frame buffer. It reads 32-bit words in order from a programmed window of word addresses. It breaks each word into 4-bit nibbles and drives them onto the panel data bus, one nibble per shift strobe. A line pulse ends every line, a frame marker covers the first line, and an AC-bias (DF) signal alternates. The width and height programmed in pixels and lines are turned inside the block into per-line nibble counts and per-frame line counts. The colour mode and the split-panel setting select the rule used.

The sequencer is a five-state machine. `ST_OFF` idles. `ST_FSTART` reloads the fetch address and clears the counters. `ST_SHIFT` emits nibbles while data is available. `ST_LEND` emits the line pulse. `ST_FEND` flags the finished frame. The transitions are:
- OFF→FSTART, taken when video is enabled and freeze is clear.
- FSTART→SHIFT, always.
- SHIFT→LEND, when the last nibble of the line goes out.
- LEND→SHIFT, when more lines remain.
- LEND→FEND, after the last line.
- FEND→FSTART, for the next frame.
- FEND→OFF, when freeze is set.
- Any state→OFF, when video enable is low.

A word source with valid/ready handshake stands in for DMA. It must present the word at `fetch_addr` whenever it raises `rd_valid`.

Top module: `lcd_frame_timer`

## Requirements
- R1: During and right after reset, with video disabled, `lcd_data`, `lcd_shclk`, `lcd_lp`, `lcd_flm`, `lcd_df`, `frame_done` and `rd_ready` are all low.
- R2: The number of shift strobes per line depends on the colour mode. With `cfg_bpp_sel` = 3 (8-bit colour; bits per pixel = 1 << select) and split off, it is (width/8)*3. In every other case it is width/4. Shift strobes and line pulses never coincide.
- R3: The number of line pulses per frame is height, or height/2 when split is on. Each line pulse lasts one cycle and follows the last strobe of its line.
- R4: Words are read from `cfg_base` upward by one word address. After `cfg_end` the address wraps to `cfg_base`, and it reloads to `cfg_base` at every frame start. Each word gives 8 nibbles, least significant nibble first, and the nibble stream continues across lines within a frame.
- R5: While `rd_valid` is low and no buffered nibble is left, no shift strobe is issued and `fetch_addr` holds. The nibble stream stays unchanged by the stall.
- R6: `lcd_flm` is high at every shift strobe of the first line of a frame and low at every other strobe.
- R7: `frame_done` is a one-cycle pulse in the cycle after the last line pulse of each frame.
- R8: Setting `cfg_freeze` lets the current frame finish and then stops all strobes and frames. Clearing `cfg_vid_en` while frozen keeps the logic halted. Clearing freeze with video enabled restarts at a new frame.
- R9: Panel pins (`lcd_data`, `lcd_shclk`, `lcd_lp`, `lcd_flm`) are driven only when both `cfg_vid_en` and `cfg_disp_on` are set. With display off, the frame timing still runs and `frame_done` keeps pulsing. With video disabled, no frames occur.
- R10: With `cfg_invert` set, every nibble on `lcd_data` is the bitwise inverse of the buffer nibble.
- R11: With `cfg_df_mode` = 0, `lcd_df` toggles exactly once per frame, at the frame start.
- R12: With `cfg_df_mode` = 1, `lcd_df` toggles after every `cfg_df_rate`+1 line pulses, regardless of frame boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vid_en | input | 1 | Video logic enable |
| cfg_disp_on | input | 1 | Display on |
| cfg_freeze | input | 1 | Stop at end of current frame |
| cfg_bpp_sel | input | 2 | Depth select (0 mono, 1 2-bit grey, 2 4-bit grey, 3 8-bit colour) |
| cfg_split | input | 1 | Split panel, halves line count |
| cfg_invert | input | 1 | Invert panel data nibbles |
| cfg_df_mode | input | 1 | 0: DF per frame, 1: DF per line-rate |
| cfg_df_rate | input | DFW | Lines per DF half-period minus one |
| cfg_width | input | GW | Panel width in pixels (multiple of 8) |
| cfg_height | input | GW | Panel height in lines (even when split) |
| cfg_base | input | AW | First word address of the buffer |
| cfg_end | input | AW | Last word address of the buffer |
| rd_valid | input | 1 | Word at fetch_addr is present |
| rd_data | input | WORD_W | Word data |
| rd_ready | output | 1 | Block accepts a word this cycle |
| fetch_addr | output | AW | Word address being requested |
| lcd_data | output | 4 | Panel data nibble |
| lcd_shclk | output | 1 | Shift strobe, one cycle per nibble |
| lcd_lp | output | 1 | Line pulse |
| lcd_flm | output | 1 | First-line frame marker |
| lcd_df | output | 1 | AC-bias signal |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
A wrong line or column counter shows within one line. The count of strobes before a line pulse, or of line pulses before `frame_done`, will be off. A fetch pointer that is off by one or misses its reload appears at the first wrong nibble on `lcd_data`. This is at most 8 strobes after the faulty word, or at the first strobe of the next frame. A freeze or gating fault shows as strobes inside a window where none may appear. A DF fault shows at the next toggle, through the number of line pulses or frames since the last one.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

    // depth select code for 8-bit colour
    localparam logic [1:0] BPP_COLOR8 = 2'd3;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_FSTART,
        ST_SHIFT,
        ST_LEND,
        ST_FEND
    } tim_state_t;

endpackage

// File: rtl/lcd_geom.sv
module lcd_geom
    import lcd_tim_pkg::*;
#(
    parameter int GW = 10
) (
    input  logic [GW-1:0] width,
    input  logic [GW-1:0] height,
    input  logic [1:0]    bpp_sel,
    input  logic          split,
    output logic [GW-1:0] h_last,
    output logic [GW-1:0] l_last
);
    localparam logic [GW+1:0] THREE = (GW+2)'(3);
    localparam logic [GW+1:0] ONE_W = (GW+2)'(1);
    localparam logic [GW-1:0] ONE   = GW'(1);

    logic [GW+1:0] color_steps;
    logic [GW+1:0] grey_steps;

    always_comb begin
        color_steps = ({2'b00, width} >> 3) * THREE;
        grey_steps  = {2'b00, width} >> 2;
        if (bpp_sel == BPP_COLOR8 && !split) begin
            h_last = GW'(color_steps - ONE_W);
        end else begin
            h_last = GW'(grey_steps - ONE_W);
        end
        if (split) begin
            l_last = (height >> 1) - ONE;
        end else begin
            l_last = height - ONE;
        end
    end

endmodule

// File: rtl/lcd_fetch.sv
module lcd_fetch #(
    parameter int AW     = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              fetch_en,
    input  logic              take_nib,
    input  logic [AW-1:0]     base_addr,
    input  logic [AW-1:0]     end_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_ready,
    output logic [AW-1:0]     fetch_addr,
    output logic              nib_avail,
    output logic [3:0]        nib_val
);
    localparam int NIBS = WORD_W / 4;
    localparam int NIW  = $clog2(NIBS);
    localparam logic [NIW-1:0] LAST_NIB = NIW'(NIBS - 1);

    logic [WORD_W-1:0] word_q;
    logic              have_word;
    logic [NIW-1:0]    nib_idx;
    logic [AW-1:0]     addr_q;
    logic [3:0]        nib_arr [NIBS];

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign nib_arr[g] = word_q[g*4 +: 4];
    end

    assign rd_ready   = fetch_en && !have_word;
    assign fetch_addr = addr_q;
    assign nib_avail  = have_word;
    assign nib_val    = nib_arr[nib_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            have_word <= 1'b0;
            nib_idx   <= '0;
            addr_q    <= '0;
        end else if (restart) begin
            have_word <= 1'b0;
            nib_idx   <= '0;
            addr_q    <= base_addr;
        end else begin
            if (rd_valid && rd_ready) begin
                word_q    <= rd_data;
                have_word <= 1'b1;
                nib_idx   <= '0;
                addr_q    <= (addr_q == end_addr) ? base_addr : addr_q + AW'(1);
            end
            if (take_nib && have_word) begin
                nib_idx <= nib_idx + NIW'(1);
                if (nib_idx == LAST_NIB) begin
                    have_word <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/lcd_df_gen.sv
module lcd_df_gen #(
    parameter int DFW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_tick,
    input  logic           line_tick,
    input  logic           rate_mode,
    input  logic [DFW-1:0] rate_val,
    output logic           df
);
    logic [DFW-1:0] line_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            df       <= 1'b0;
            line_cnt <= '0;
        end else if (!rate_mode) begin
            line_cnt <= '0;
            if (frame_tick) begin
                df <= ~df;
            end
        end else if (line_tick) begin
            if (line_cnt >= rate_val) begin
                line_cnt <= '0;
                df       <= ~df;
            end else begin
                line_cnt <= line_cnt + DFW'(1);
            end
        end
    end

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_tim_pkg::*;
#(
    parameter int AW     = 16,
    parameter int WORD_W = 32,
    parameter int GW     = 10,
    parameter int DFW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_vid_en,
    input  logic              cfg_disp_on,
    input  logic              cfg_freeze,
    input  logic [1:0]        cfg_bpp_sel,
    input  logic              cfg_split,
    input  logic              cfg_invert,
    input  logic              cfg_df_mode,
    input  logic [DFW-1:0]    cfg_df_rate,
    input  logic [GW-1:0]     cfg_width,
    input  logic [GW-1:0]     cfg_height,
    input  logic [AW-1:0]     cfg_base,
    input  logic [AW-1:0]     cfg_end,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_ready,
    output logic [AW-1:0]     fetch_addr,
    output logic [3:0]        lcd_data,
    output logic              lcd_shclk,
    output logic              lcd_lp,
    output logic              lcd_flm,
    output logic              lcd_df,
    output logic              frame_done
);
    tim_state_t    state, nxt;
    logic [GW-1:0] h_cnt, l_cnt;
    logic [GW-1:0] h_last, l_last;
    logic          nib_avail;
    logic [3:0]    nib_val;
    logic          emit;
    logic          panel_en;
    logic          first_line;

    logic [3:0]    data_q;
    logic          shclk_q, lp_q, flm_q, fdone_q;

    lcd_geom #(.GW(GW)) geom_i (
        .width   (cfg_width),
        .height  (cfg_height),
        .bpp_sel (cfg_bpp_sel),
        .split   (cfg_split),
        .h_last  (h_last),
        .l_last  (l_last)
    );

    lcd_fetch #(.AW(AW), .WORD_W(WORD_W)) fetch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (state == ST_FSTART),
        .fetch_en   (state == ST_SHIFT),
        .take_nib   (emit),
        .base_addr  (cfg_base),
        .end_addr   (cfg_end),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_ready   (rd_ready),
        .fetch_addr (fetch_addr),
        .nib_avail  (nib_avail),
        .nib_val    (nib_val)
    );

    lcd_df_gen #(.DFW(DFW)) df_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (state == ST_FSTART),
        .line_tick  (state == ST_LEND),
        .rate_mode  (cfg_df_mode),
        .rate_val   (cfg_df_rate),
        .df         (lcd_df)
    );

    assign emit       = (state == ST_SHIFT) && nib_avail;
    assign panel_en   = cfg_vid_en && cfg_disp_on;
    assign first_line = ((state == ST_SHIFT) || (state == ST_LEND)) && (l_cnt == '0);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:    if (cfg_vid_en && !cfg_freeze) nxt = ST_FSTART;
            ST_FSTART: nxt = ST_SHIFT;
            ST_SHIFT:  if (emit && (h_cnt >= h_last)) nxt = ST_LEND;
            ST_LEND:   nxt = (l_cnt >= l_last) ? ST_FEND : ST_SHIFT;
            ST_FEND:   nxt = cfg_freeze ? ST_OFF : ST_FSTART;
            default:   nxt = ST_OFF;
        endcase
        if (!cfg_vid_en) begin
            nxt = ST_OFF;
        end
    end

    // state register and position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            h_cnt <= '0;
            l_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_FSTART) begin
                h_cnt <= '0;
                l_cnt <= '0;
            end else if (emit) begin
                h_cnt <= (h_cnt >= h_last) ? '0 : h_cnt + GW'(1);
            end else if (state == ST_LEND && l_cnt < l_last) begin
                l_cnt <= l_cnt + GW'(1);
            end
        end
    end

    // registered panel outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            shclk_q <= 1'b0;
            lp_q    <= 1'b0;
            flm_q   <= 1'b0;
            fdone_q <= 1'b0;
        end else begin
            shclk_q <= panel_en && emit;
            lp_q    <= panel_en && (state == ST_LEND);
            flm_q   <= panel_en && first_line;
            fdone_q <= (state == ST_FEND);
            if (!panel_en) begin
                data_q <= '0;
            end else if (emit) begin
                data_q <= nib_val ^ {4{cfg_invert}};
            end
        end
    end

    assign lcd_data   = data_q;
    assign lcd_shclk  = shclk_q;
    assign lcd_lp     = lp_q;
    assign lcd_flm    = flm_q;
    assign frame_done = fdone_q;

endmodule

// File: rtl/lcd_frame_timer_chk.sv
module lcd_frame_timer_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_vid_en,
    input logic          cfg_disp_on,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [AW-1:0] fetch_addr,
    input logic [3:0]    lcd_data,
    input logic          lcd_shclk,
    input logic          lcd_lp,
    input logic          lcd_flm,
    input logic          frame_done
);
    // R7
    frame_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R3
    line_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_lp |=> !lcd_lp);

    // R2
    strobe_line_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lcd_shclk && lcd_lp));

    // R9
    panel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_vid_en && cfg_disp_on) |-> !(lcd_shclk || lcd_lp || lcd_flm));

    // R9
    panel_data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_vid_en && cfg_disp_on) |-> (lcd_data == 4'h0));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && !rd_valid) |=> $stable(fetch_addr));

    // R7
    done_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && lcd_shclk));

endmodule

bind lcd_frame_timer lcd_frame_timer_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_vid_en (cfg_vid_en),
    .cfg_disp_on(cfg_disp_on),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .fetch_addr (fetch_addr),
    .lcd_data   (lcd_data),
    .lcd_shclk  (lcd_shclk),
    .lcd_lp     (lcd_lp),
    .lcd_flm    (lcd_flm),
    .frame_done (frame_done)
);

// File: tb/lcd_frame_timer_tb.sv
module lcd_frame_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int WW = 32;
    localparam int GW = 10;
    localparam int DFW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_vid_en = 1'b0, cfg_disp_on = 1'b0, cfg_freeze = 1'b0;
    logic [1:0] cfg_bpp_sel = 2'd1;
    logic cfg_split = 1'b0, cfg_invert = 1'b0, cfg_df_mode = 1'b0;
    logic [DFW-1:0] cfg_df_rate = '0;
    logic [GW-1:0] cfg_width = GW'(16), cfg_height = GW'(4);
    logic [AW-1:0] cfg_base = '0, cfg_end = '0;
    logic rd_valid = 1'b1;
    logic [WW-1:0] rd_data;
    logic rd_ready;
    logic [AW-1:0] fetch_addr;
    logic [3:0] lcd_data;
    logic lcd_shclk, lcd_lp, lcd_flm, lcd_df, frame_done;

    int n_chk = 0;
    int n_fail = 0;

    // expectations
    int e_h, e_l, e_base, e_end, e_rate;
    bit e_inv, e_dmode, mon_on, stall;
    int scnt = 0;

    // monitor state
    int k, sh_in_line, line_idx, lp_since_df, df_tog;
    logic df_prev;
    int sh_total = 0, lp_total = 0, fd_total = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] word_of(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C, ~a[7:0], a[7:0]};
    endfunction

    assign rd_data = word_of(fetch_addr);

    function automatic logic [3:0] exp_nib(input int idx);
        int w = idx / 8;
        int nb = idx % 8;
        int span = e_end - e_base + 1;
        logic [31:0] wd = word_of(AW'(e_base + (w % span)));
        return wd[nb*4 +: 4] ^ {4{e_inv}};
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    lcd_frame_timer #(.AW(AW), .WORD_W(WW), .GW(GW), .DFW(DFW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_vid_en(cfg_vid_en), .cfg_disp_on(cfg_disp_on), .cfg_freeze(cfg_freeze),
        .cfg_bpp_sel(cfg_bpp_sel), .cfg_split(cfg_split), .cfg_invert(cfg_invert),
        .cfg_df_mode(cfg_df_mode), .cfg_df_rate(cfg_df_rate),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_base(cfg_base), .cfg_end(cfg_end),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
        .fetch_addr(fetch_addr), .lcd_data(lcd_data), .lcd_shclk(lcd_shclk),
        .lcd_lp(lcd_lp), .lcd_flm(lcd_flm), .lcd_df(lcd_df), .frame_done(frame_done)
    );

    // word source: stall pattern gives data one cycle in three
    always @(negedge clk) begin
        scnt <= scnt + 1;
        rd_valid <= stall ? ((scnt % 3) == 0) : 1'b1;
    end

    // port monitor
    always @(negedge clk) begin
        if (lcd_shclk) begin
            sh_total++;
            if (mon_on) begin
                check(lcd_data == exp_nib(k), "R4/R10 nibble", lcd_data, exp_nib(k));
                check(lcd_flm == (line_idx == 0), "R6 frame marker", lcd_flm, line_idx == 0);
            end
            k++;
            sh_in_line++;
        end
        if (lcd_lp) begin
            lp_total++;
            if (mon_on) check(sh_in_line == e_h, "R2 strobes per line", sh_in_line, e_h);
            sh_in_line = 0;
            line_idx++;
            lp_since_df++;
        end
        if (lcd_df !== df_prev) begin
            df_prev = lcd_df;
            df_tog++;
            if (mon_on && e_dmode)
                check(lp_since_df == e_rate + 1, "R12 lines per DF toggle", lp_since_df, e_rate + 1);
            lp_since_df = 0;
        end
        if (frame_done) begin
            fd_total++;
            if (mon_on) begin
                check(line_idx == e_l, "R3 lines per frame", line_idx, e_l);
                if (!e_dmode) check(df_tog == 1, "R11 DF toggles per frame", df_tog, 1);
            end
            line_idx = 0;
            k = 0;
            df_tog = 0;
        end
    end

    task automatic start(input logic [1:0] bpp, input bit split, input int w, input int h,
                         input int base, input int last, input bit inv,
                         input bit dmode, input int rate, input bit stl);
        rst_n = 1'b0;
        mon_on = 1'b0;
        cfg_vid_en = 1'b0; cfg_disp_on = 1'b0; cfg_freeze = 1'b0;
        cfg_bpp_sel = bpp; cfg_split = split; cfg_invert = inv;
        cfg_df_mode = dmode; cfg_df_rate = DFW'(rate);
        cfg_width = GW'(w); cfg_height = GW'(h);
        cfg_base = AW'(base); cfg_end = AW'(last);
        stall = stl;
        e_h = (bpp == 2'd3 && !split) ? (w / 8) * 3 : w / 4;
        e_l = split ? h / 2 : h;
        e_base = base; e_end = last; e_inv = inv; e_dmode = dmode; e_rate = rate;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        k = 0; sh_in_line = 0; line_idx = 0; lp_since_df = 0; df_tog = 0;
        df_prev = lcd_df;
        mon_on = 1'b1;
        cfg_vid_en = 1'b1;
        cfg_disp_on = 1'b1;
    endtask

    task automatic wait_frames(input int n, input string tag);
        int tgt = fd_total + n;
        int c = 0;
        while (fd_total < tgt && c < 20000) begin
            @(negedge clk);
            c++;
        end
        check(fd_total >= tgt, tag, fd_total, tgt);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cfg_vid_en = 1'b0;
        repeat (3) @(negedge clk);
        check({lcd_data, lcd_shclk, lcd_lp, lcd_flm, lcd_df, frame_done, rd_ready} == '0,
              "R1 outputs in reset", {lcd_data, lcd_shclk, lcd_lp, lcd_flm, lcd_df, frame_done, rd_ready}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({lcd_data, lcd_shclk, lcd_lp, lcd_flm, lcd_df, frame_done, rd_ready} == '0,
              "R1 outputs after reset", {lcd_data, lcd_shclk, lcd_lp, lcd_flm, lcd_df, frame_done, rd_ready}, 0);
    endtask

    // R2 R3 R4 R6 R7 R11: grey mode, window wraps inside a frame
    task automatic t_grey;
        start(2'd1, 1'b0, 32, 4, 'h10, 'h12, 1'b0, 1'b0, 0, 1'b0);
        wait_frames(3, "R7 grey frames complete");
    endtask

    // R2: 8-bit colour without split
    task automatic t_color;
        start(2'd3, 1'b0, 16, 5, 'h40, 'h4F, 1'b0, 1'b0, 0, 1'b0);
        wait_frames(2, "R2 colour frames complete");
    endtask

    // R2 R3: 8-bit colour with split halves lines, count uses width/4
    task automatic t_split;
        start(2'd3, 1'b1, 16, 6, 'h80, 'h8F, 1'b0, 1'b0, 0, 1'b0);
        wait_frames(2, "R3 split frames complete");
    endtask

    // R5: data source stalls
    task automatic t_stall;
        start(2'd0, 1'b0, 24, 3, 'h20, 'h23, 1'b0, 1'b0, 0, 1'b1);
        wait_frames(2, "R5 stalled frames complete");
        stall = 1'b0;
    endtask

    // R10: inverted data bus
    task automatic t_invert;
        start(2'd2, 1'b0, 16, 3, 'h05, 'h09, 1'b1, 1'b0, 0, 1'b0);
        wait_frames(2, "R10 inverted frames complete");
    endtask

    // R12: DF at line rate
    task automatic t_df_rate;
        int t0;
        start(2'd1, 1'b0, 8, 5, 'h00, 'h07, 1'b0, 1'b1, 2, 1'b0);
        t0 = lp_total;
        wait_frames(3, "R12 frames complete");
        check(lp_total - t0 >= 15, "R12 line pulses seen", lp_total - t0, 15);
    endtask

    // R8: freeze at end of frame
    task automatic t_freeze;
        int c = 0;
        int s0, f0;
        start(2'd1, 1'b0, 16, 4, 'h30, 'h3F, 1'b0, 1'b0, 0, 1'b0);
        while (line_idx < 2 && c < 5000) begin @(negedge clk); c++; end
        f0 = fd_total;
        cfg_freeze = 1'b1;
        wait_frames(1, "R8 frozen frame still finishes");
        check(fd_total == f0 + 1, "R8 exactly one frame after freeze", fd_total, f0 + 1);
        s0 = sh_total; f0 = fd_total;
        repeat (200) @(negedge clk);
        check(sh_total == s0 && fd_total == f0, "R8 halted after freeze", sh_total - s0, 0);
        cfg_vid_en = 1'b0;
        repeat (20) @(negedge clk);
        cfg_vid_en = 1'b1;
        s0 = sh_total;
        repeat (200) @(negedge clk);
        check(sh_total == s0, "R8 enable clear keeps halt", sh_total - s0, 0);
        cfg_freeze = 1'b0;
        wait_frames(2, "R8 resumes after freeze clear");
    endtask

    // R9: panel gating
    task automatic t_gate;
        int s0, l0, f0;
        start(2'd1, 1'b0, 16, 3, 'h00, 'h0F, 1'b0, 1'b0, 0, 1'b0);
        mon_on = 1'b0;
        cfg_disp_on = 1'b0;
        repeat (3) @(negedge clk);
        s0 = sh_total; l0 = lp_total; f0 = fd_total;
        repeat (300) @(negedge clk);
        check(sh_total == s0 && lp_total == l0, "R9 display off pins quiet", sh_total - s0, 0);
        check(lcd_data == 4'h0, "R9 display off data low", lcd_data, 0);
        check(fd_total > f0, "R9 timing runs with display off", fd_total - f0, 1);
        cfg_disp_on = 1'b1;
        cfg_vid_en = 1'b0;
        repeat (3) @(negedge clk);
        f0 = fd_total; s0 = sh_total;
        repeat (300) @(negedge clk);
        check(fd_total == f0 && sh_total == s0, "R9 video off stops frames", fd_total - f0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        mon_on = 1'b0;
        stall = 1'b0;
        t_reset();
        t_grey();
        t_color();
        t_split();
        t_stall();
        t_invert();
        t_df_rate();
        t_freeze();
        t_gate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule